// File: doc/BRIEF.md
# SPI memory command engine

This block is an SPI master aimed at serial flash parts. Software programs it through a small 32-bit register bus. The bus has a combinational read path and single-cycle writes. One write to the second control register starts one of three transfers:

- A generic transfer shifts out one to four command/address bytes from the transmit register. It then clocks in up to seven response bytes.
- A status poll sends the flash status opcode on its own. It returns the byte it reads in the status register.
- A write-enable command sends that opcode alone.

A two-bit bank field routes the transfer to one of four active-low chip selects. Every transfer raises a sticky completion flag. Software polls that flag and clears it by writing zero to it. The serial side uses clock polarity and phase both high. SCK is the system clock divided by an even parameter. Chip select frames the whole transfer with half an SCK period of margin at each end.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every register reads zero, all chip selects are high and SCK is high. The register offsets are: 0x00 control 1, 0x04 control 2, 0x08 status, 0x0C transmit, 0x10 receive. Control 1 keeps only bits 29 (write-burst) and 28 (software mode); its other bits read zero.
- R2: SCK idles high. MOSI changes on SCK falling edges and MISO is sampled on rising edges. Each byte goes most significant bit first. One SCK period is CLK_DIV system clocks. MOSI is low whenever no chip select is asserted.
- R3: Writing control 2 with bit 7 set starts a generic transfer, using these fields:
  - Bits [2:0] give the transmit byte count; values above 4 count as 4.
  - Bits [6:4] give the receive byte count, 0 to 7.
  - Transmit bytes leave the transmit register lowest byte first.
  - Receive bytes follow the transmit bytes directly, inside one chip-select assertion.
- R4: At the end of a generic transfer, the receive register is replaced. Received byte k lands in bits [8k+7:8k]. Bytes past the fourth are clocked but dropped, and bytes not received read zero.
- R5: Control 2 bit 10 makes the engine send opcode 0x05 and read one byte into status bits [7:0]. The receive register is left unchanged.
- R6: Control 2 bit 11 makes the engine send opcode 0x06 alone, with exactly 8 SCK cycles.
- R7: Control 2 bits [13:12] select which chip select is driven low for the transfer. At most one chip select is ever low.
- R8: Chip select falls one half SCK period before the first SCK falling edge. It rises one half period after the last rising edge. SCK toggles only while a chip select is low.
- R9: Status bit 8 sets when a transfer completes and stays set. Writing the status register with bit 8 at 0 clears it; writing bit 8 at 1 leaves it unchanged.
- R10: Status bit 9 reads 1 while a transfer runs. A control 2 write during that time is ignored entirely: its fields are not stored and it starts nothing.
- R11: When several start bits are set, generic (bit 7) wins over status read (bit 10), which wins over write enable (bit 11). Control 2 reads back bits [13:12], [6:4] and [2:0] only, so start bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 4 | Active-low chip selects, one per bank |

## Verification
The assertions check the pin-level rules on every cycle:
- at most one chip select low;
- SCK high and MOSI low while deselected;
- no SCK movement outside a framed transfer;
- a stable chip select during a transfer;
- a completion flag visible on a status read right after the transfer ends.

Only the bench scenarios can show the content rules. Those cover byte order and packing, the transmit-count clamp, the dropped extra receive bytes, the opcodes of the fixed commands, start-bit priority, the sticky clear semantics and the ignored control write. They need a flash model and known responses. The half-period setup and hold margins and the SCK period are measured by the bench as well.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam logic [4:0] ADDR_CTRL1 = 5'h00;
  localparam logic [4:0] ADDR_CTRL2 = 5'h04;
  localparam logic [4:0] ADDR_STAT  = 5'h08;
  localparam logic [4:0] ADDR_TXD   = 5'h0C;
  localparam logic [4:0] ADDR_RXD   = 5'h10;

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  localparam int NUM_CS   = 4;
  localparam int MAX_TX   = 4;

  typedef enum logic [1:0] {
    XK_GENERIC = 2'd0,
    XK_STATUS  = 2'd1,
    XK_WREN    = 2'd2
  } xfer_kind_e;

  typedef struct packed {
    xfer_kind_e  kind;
    logic [1:0]  bank;
    logic [2:0]  tx_cnt;
    logic [2:0]  rx_cnt;
    logic [31:0] tx_word;
  } launch_t;
endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(HALF) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CNT_W'(HALF - 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic              fin,
  input  xfer_kind_e        fin_kind,
  input  logic [31:0]       rx_word,
  output logic              start,
  output launch_t           launch
);
  logic        wburst_q, swmode_q;
  logic [1:0]  bank_q;
  logic [2:0]  txf_q, rxf_q;
  logic [31:0] txd_q, rxd_q;
  logic [7:0]  fstat_q;
  logic        done_q, done_d;

  logic hit_c1, hit_c2, hit_st, hit_tx, hit_rx;
  logic ctrl1_en, ctrl2_en, txd_en, rxd_en, fst_en;

  assign hit_c1 = (bus_addr == ADDR_W'(ADDR_CTRL1));
  assign hit_c2 = (bus_addr == ADDR_W'(ADDR_CTRL2));
  assign hit_st = (bus_addr == ADDR_W'(ADDR_STAT));
  assign hit_tx = (bus_addr == ADDR_W'(ADDR_TXD));
  assign hit_rx = (bus_addr == ADDR_W'(ADDR_RXD));

  // R10: control 2 is locked while a transfer runs
  assign ctrl1_en = bus_we && hit_c1;
  assign ctrl2_en = bus_we && hit_c2 && !busy;
  assign txd_en   = bus_we && hit_tx;
  assign rxd_en   = fin && (fin_kind == XK_GENERIC);   // R4
  assign fst_en   = fin && (fin_kind == XK_STATUS);    // R5

  assign start = ctrl2_en && (bus_wdata[7] || bus_wdata[10] || bus_wdata[11]);

  // R11: generic beats status read beats write enable
  always_comb begin
    launch.bank = bus_wdata[13:12];
    if (bus_wdata[7]) begin
      launch.kind    = XK_GENERIC;
      launch.tx_cnt  = (bus_wdata[2:0] > 3'(MAX_TX)) ? 3'(MAX_TX) : bus_wdata[2:0];
      launch.rx_cnt  = bus_wdata[6:4];
      launch.tx_word = txd_q;
    end else if (bus_wdata[10]) begin
      launch.kind    = XK_STATUS;
      launch.tx_cnt  = 3'd1;
      launch.rx_cnt  = 3'd1;
      launch.tx_word = {24'd0, OP_RDSR};
    end else begin
      launch.kind    = XK_WREN;
      launch.tx_cnt  = 3'd1;
      launch.rx_cnt  = 3'd0;
      launch.tx_word = {24'd0, OP_WREN};
    end
  end

  // R9: set wins over a clearing write in the same cycle
  always_comb begin
    if (fin)                                done_d = 1'b1;
    else if (bus_we && hit_st && !bus_wdata[8]) done_d = 1'b0;
    else                                    done_d = done_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_c1) bus_rdata = {2'b00, wburst_q, swmode_q, 28'd0};
    if (hit_c2) bus_rdata = {18'd0, bank_q, 5'd0, rxf_q, 1'b0, txf_q};
    if (hit_st) bus_rdata = {22'd0, busy, done_q, fstat_q};
    if (hit_tx) bus_rdata = txd_q;
    if (hit_rx) bus_rdata = rxd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wburst_q <= 1'b0;
      swmode_q <= 1'b0;
      bank_q   <= '0;
      txf_q    <= '0;
      rxf_q    <= '0;
      txd_q    <= '0;
      rxd_q    <= '0;
      fstat_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      if (ctrl1_en) begin
        wburst_q <= bus_wdata[29];
        swmode_q <= bus_wdata[28];
      end
      if (ctrl2_en) begin
        bank_q <= bus_wdata[13:12];
        rxf_q  <= bus_wdata[6:4];
        txf_q  <= bus_wdata[2:0];
      end
      if (txd_en) txd_q   <= bus_wdata;
      if (rxd_en) rxd_q   <= rx_word;
      if (fst_en) fstat_q <= rx_word[7:0];
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  launch_t           launch,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              fin,
  output xfer_kind_e        fin_kind,
  output logic [31:0]       rx_word,
  output logic              sck,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n
);
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD} seq_state_e;

  seq_state_e  state_q, state_d;
  logic        sck_q, sck_d, mosi_q, mosi_d;
  logic [6:0]  idx_q, idx_d, total_q;
  logic [2:0]  txb_q;
  xfer_kind_e  kind_q;
  logic [1:0]  bank_q;
  logic [31:0] txw_q, rxw_q, rxw_d;
  logic        ld;

  logic [3:0] byte_i, rx_byte;
  logic [2:0] bit_i;
  logic       tx_bit, rx_hit;
  logic [4:0] tx_pos, rx_pos;

  // R2/R3: MSB first within a byte, lowest byte of the word first
  assign byte_i  = idx_q[6:3];
  assign bit_i   = 3'd7 - idx_q[2:0];
  assign tx_pos  = {byte_i[1:0], bit_i};
  assign tx_bit  = (byte_i < {1'b0, txb_q}) ? txw_q[tx_pos] : 1'b0;
  // R4: receive bytes pack upward from bit 0, beyond four are dropped
  assign rx_byte = byte_i - {1'b0, txb_q};
  assign rx_hit  = (byte_i >= {1'b0, txb_q}) && (rx_byte < 4'd4);
  assign rx_pos  = {rx_byte[1:0], bit_i};

  assign ld = (state_q == S_IDLE) && start;

  always_comb begin
    state_d = state_q;
    sck_d   = sck_q;
    mosi_d  = mosi_q;
    idx_d   = idx_q;
    rxw_d   = rxw_q;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_SETUP;
          idx_d   = '0;
          rxw_d   = '0;
          sck_d   = 1'b1;
          mosi_d  = 1'b0;
        end
      end
      S_SETUP: begin
        if (tick) begin
          if (total_q == 7'd0) begin
            state_d = S_HOLD;
          end else begin
            state_d = S_SHIFT;
            sck_d   = 1'b0;
            mosi_d  = tx_bit;
          end
        end
      end
      S_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
            if (rx_hit) rxw_d[rx_pos] = miso;
            if (idx_q == total_q - 7'd1) state_d = S_HOLD;
            else                         idx_d   = idx_q + 7'd1;
          end else begin
            sck_d  = 1'b0;
            mosi_d = tx_bit;
          end
        end
      end
      S_HOLD: begin
        if (tick) begin
          state_d = S_IDLE;
          mosi_d  = 1'b0;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sck_q   <= 1'b1;
      mosi_q  <= 1'b0;
      idx_q   <= '0;
      rxw_q   <= '0;
      total_q <= '0;
      txb_q   <= '0;
      kind_q  <= XK_GENERIC;
      bank_q  <= '0;
      txw_q   <= '0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      mosi_q  <= mosi_d;
      idx_q   <= idx_d;
      rxw_q   <= rxw_d;
      if (ld) begin
        total_q <= {({1'b0, launch.tx_cnt} + {1'b0, launch.rx_cnt}), 3'b000};
        txb_q   <= launch.tx_cnt;
        kind_q  <= launch.kind;
        bank_q  <= launch.bank;
        txw_q   <= launch.tx_word;
      end
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign fin      = (state_q == S_HOLD) && tick;
  assign fin_kind = kind_q;
  assign rx_word  = rxw_q;
  assign sck      = sck_q;
  assign mosi     = mosi_q;

  // R7: one-hot active-low select for the latched bank
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(busy && (bank_q == 2'(g)));
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [3:0]        spi_cs_n
);
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic        start_w, busy_w, fin_w, tick_w;
  launch_t     launch_w;
  xfer_kind_e  kind_w;
  logic [31:0] rx_w;

  spi_eng_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .busy      (busy_w),
    .fin       (fin_w),
    .fin_kind  (kind_w),
    .rx_word   (rx_w),
    .start     (start_w),
    .launch    (launch_w)
  );

  spi_eng_tick #(.HALF(HALF)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (busy_w),
    .tick  (tick_w)
  );

  spi_eng_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start_w),
    .launch   (launch_w),
    .tick     (tick_w),
    .miso     (spi_miso),
    .busy     (busy_w),
    .fin      (fin_w),
    .fin_kind (kind_w),
    .rx_word  (rx_w),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .cs_n     (spi_cs_n)
  );
endmodule

// File: rtl/spi_eng_checker.sv
module spi_eng_checker
  import spi_eng_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic [3:0]        spi_cs_n,
  input logic              busy,
  input logic              fin
);
  // R7
  p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R2
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&spi_cs_n) |-> spi_sck);

  // R2
  p_mosi_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&spi_cs_n) |-> !spi_mosi);

  // R8
  p_sck_framed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_sck) |-> !(&spi_cs_n));

  // R3
  p_cs_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spi_cs_n));

  // R9
  p_done_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (bus_addr != ADDR_W'(ADDR_STAT)) || bus_rdata[8]);
endmodule

bind spi_cmd_engine spi_eng_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .spi_sck   (spi_sck),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n),
  .busy      (busy_w),
  .fin       (fin_w)
);

// File: tb/spi_cmd_engine_tb_top.sv
module spi_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  localparam logic [4:0] A_C1 = 5'h00, A_C2 = 5'h04, A_ST = 5'h08, A_TX = 5'h0C, A_RX = 5'h10;

  // {transmit word, control 2 value, expected receive register}
  localparam logic [95:0] VEC [6] = '{
    {32'h0000009F, 32'h000000B1, 32'h001720C2},
    {32'h44332211, 32'h000010A4, 32'h00003534},
    {32'h000000AB, 32'h00002081, 32'h00000000},
    {32'h00CCBB03, 32'h000030C3, 32'h36353433},
    {32'h00005507, 32'h000000F2, 32'h35343332},
    {32'h0A0B0C0D, 32'h00001096, 32'h00000034}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        sck, mosi;
  logic        miso = 1'b1;
  logic [3:0]  cs_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(DIV), .ADDR_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_rdata(rdata), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  int checks = 0;
  int fails  = 0;
  bit run_over = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] m_bytes [16];
  logic [7:0] m_sh;
  logic [7:0] sreg = 8'h80;
  int  m_bit = 0, m_rises = 0, m_bank = -1;
  time t_csf = 0, t_ff = 0, t_lr = 0, t_csr = 0, t_prev_r = 0, t_per = 0;
  bit  ff_seen = 0;
  wire cs_all = &cs_n;

  function automatic logic [7:0] resp(input int b);
    if (b == 0) return 8'hFF;
    if (m_bytes[0] == 8'h05) return sreg;
    if (m_bytes[0] == 8'h9F) begin
      if (b == 1) return 8'hC2;
      if (b == 2) return 8'h20;
      if (b == 3) return 8'h17;
      return 8'h00;
    end
    return 8'(8'h30 + b);
  endfunction

  always @(negedge cs_all) begin
    m_bit = 0; m_rises = 0; ff_seen = 0; t_csf = $time;
    for (int k = 0; k < 16; k++) m_bytes[k] = 8'h00;
    for (int k = 0; k < 4; k++) if (cs_n[k] == 1'b0) m_bank = k;
    miso = resp(0)[7];
  end

  always @(posedge sck) if (!cs_all) begin
    m_sh = {m_sh[6:0], mosi};
    if (m_bit % 8 == 7) m_bytes[m_bit / 8] = m_sh;
    m_bit++;
    m_rises++;
    if (m_rises > 1) t_per = $time - t_prev_r;
    t_prev_r = $time;
    t_lr = $time;
  end

  always @(negedge sck) if (!cs_all) begin
    if (!ff_seen) t_ff = $time;
    ff_seen = 1;
    miso = resp(m_bit / 8)[7 - (m_bit % 8)];
  end

  always @(posedge cs_all) begin
    t_csr = $time;
    if (m_bytes[0] == 8'h06 && m_rises == 8) sreg = sreg | 8'h02;
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    int n = 0;
    s = '0;
    while (s[8] !== 1'b1 && n < 5000) begin
      rd(A_ST, s);
      n++;
    end
    chk(req, {31'd0, s[8]}, 32'd1);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] r;
    int txn, rxn;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(A_C1, r); chk("R1 ctrl1 reset", r, 32'h0);
    rd(A_C2, r); chk("R1 ctrl2 reset", r, 32'h0);
    rd(A_ST, r); chk("R1 status reset", r, 32'h0);
    rd(A_TX, r); chk("R1 tx reset", r, 32'h0);
    rd(A_RX, r); chk("R1 rx reset", r, 32'h0);
    chk("R1 cs idle", {28'd0, cs_n}, 32'hF);
    chk("R1 sck idle", {31'd0, sck}, 32'd1);

    // R1: only mode bits 29 and 28 held in control 1
    wr(A_C1, 32'hFFFFFFFF);
    rd(A_C1, r); chk("R1 ctrl1 bits", r, 32'h30000000);
    wr(A_C1, 32'h20000000);
    rd(A_C1, r); chk("R1 ctrl1 burst only", r, 32'h20000000);

    // R3 R4 R7 R11: vector table of generic transfers
    for (int i = 0; i < 6; i++) begin
      logic [31:0] vtx, vc2, vexp;
      vtx = VEC[i][95:64]; vc2 = VEC[i][63:32]; vexp = VEC[i][31:0];
      txn = (vc2[2:0] > 3'd4) ? 4 : int'(vc2[2:0]);
      rxn = int'(vc2[6:4]);
      wr(A_TX, vtx);
      wr(A_ST, 32'h0);
      wr(A_C2, vc2);
      wait_done("R9 done after generic");
      rd(A_RX, r); chk($sformatf("R4 rx vec%0d", i), r, vexp);
      chk($sformatf("R3 clocks vec%0d", i), m_rises, 8 * (txn + rxn));
      for (int k = 0; k < txn; k++)
        chk($sformatf("R3 tx byte%0d vec%0d", k, i), {24'd0, m_bytes[k]}, {24'd0, vtx[8*k +: 8]});
      chk($sformatf("R7 bank vec%0d", i), m_bank, int'(vc2[13:12]));
      rd(A_C2, r); chk($sformatf("R11 ctrl2 readback vec%0d", i), r, vc2 & 32'h00003077);
    end

    // R8 R2: framing margins and SCK period of the last transfer
    chk("R8 setup half period", 32'(t_ff - t_csf), 32'(HALF * CLK_PERIOD));
    chk("R8 hold half period", 32'(t_csr - t_lr), 32'(HALF * CLK_PERIOD));
    chk("R2 sck period", 32'(t_per), 32'(DIV * CLK_PERIOD));

    // R5: status read before write enable; receive register untouched
    wr(A_ST, 32'h0);
    wr(A_C2, 32'h00001400);
    wait_done("R9 done after status read");
    chk("R5 opcode", {24'd0, m_bytes[0]}, 32'h05);
    chk("R5 clocks", m_rises, 16);
    chk("R7 status bank", m_bank, 1);
    rd(A_ST, r); chk("R5 status byte", {24'd0, r[7:0]}, 32'h80);
    rd(A_RX, r); chk("R5 rx unchanged", r, 32'h00000034);

    // R6: write enable, then status read shows the latch
    wr(A_ST, 32'h0);
    wr(A_C2, 32'h00000800);
    wait_done("R9 done after write enable");
    chk("R6 opcode", {24'd0, m_bytes[0]}, 32'h06);
    chk("R6 clocks", m_rises, 8);
    wr(A_ST, 32'h0);
    wr(A_C2, 32'h00000400);
    wait_done("R9 done after second status read");
    rd(A_ST, r); chk("R6 flash latched", {24'd0, r[7:0]}, 32'h82);

    // R9: sticky flag, write 1 keeps, write 0 clears
    wr(A_ST, 32'h00000100);
    rd(A_ST, r); chk("R9 write one keeps", {31'd0, r[8]}, 32'd1);
    wr(A_ST, 32'h0);
    rd(A_ST, r); chk("R9 write zero clears", {31'd0, r[8]}, 32'd0);

    // R10: busy bit and ignored control write
    wr(A_TX, 32'h00000011);
    wr(A_C2, 32'h000010A1);
    rd(A_ST, r); chk("R10 busy bit", {31'd0, r[9]}, 32'd1);
    wr(A_C2, 32'h000030F4);
    wait_done("R9 done after locked write");
    chk("R10 bank kept", m_bank, 1);
    chk("R10 clocks kept", m_rises, 24);
    rd(A_C2, r); chk("R10 ctrl2 kept", r, 32'h00001021);
    repeat (40) @(negedge clk);
    chk("R10 no second transfer", {28'd0, cs_n}, 32'hF);

    // R11: all start bits set, generic wins
    wr(A_TX, 32'h0000005A);
    wr(A_ST, 32'h0);
    wr(A_C2, 32'h00000C81);
    wait_done("R9 done after priority");
    chk("R11 generic wins", {24'd0, m_bytes[0]}, 32'h5A);
    chk("R11 generic clocks", m_rises, 8);
    rd(A_C2, r); chk("R11 start bits read zero", r, 32'h00000001);

    run_over = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!run_over) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule